// File: doc/BRIEF.md
# Tag-routed memory response broadcaster

This block sits at the return side of a shared memory path. A single stream of memory responses arrives, each carrying a channel tag beside its address and data. The tag names exactly one of `NUM_PROC + 1` destinations: one result printer and `NUM_PROC` processor caches. The block forwards each response to that destination only and drops the tag on the way.

The full address has two parts. Its upper bits hold a per-processor prefix and its lower `LOCAL_AW` bits hold the local address. Processor destinations see only the local address. The result printer sees the full address.

Every port uses a valid/ready handshake, and any handshake may stall for any number of cycles. An optional output register stage, on by default, cuts the ready path. One entry is held at a time, so the order of responses to each destination is kept. A tag that names no destination is accepted at once and discarded, and an error flag pulses.

Top module: `bcast_resp_router`

## Requirements
- R1: A response with tag value 0 is delivered on the printer output with its full `FULL_AW`-bit address and its data unchanged.
- R2: A response with tag value k+1 (0 <= k < `NUM_PROC`) is delivered on processor output k. The address there is the lower `LOCAL_AW` bits of the input address. Processor k's address and data occupy bits `[k*LOCAL_AW +: LOCAL_AW]` and `[k*DATA_W +: DATA_W]` of the flat output vectors.
- R3: At most one output valid is high in any cycle, and only the selected destination's valid is high.
- R4: While the selected output holds valid without ready, its valid, address and data stay unchanged. For a response with a good tag, `in_ready` is low during that time.
- R5: A response whose tag exceeds `NUM_PROC` sees `in_ready` high in the same cycle. It raises no output valid. `bad_tag_err` is high for exactly the one cycle that follows its acceptance.
- R6: With the register stage on, a response accepted at a clock edge is presented from that edge onward. While the destination is ready, one response per cycle passes through.
- R7: Responses to the same destination leave in the order they were accepted, including across stalls.
- R8: Reset (synchronous, active high) clears every output valid and `bad_tag_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input response valid |
| in_ready | output | 1 | Input response accepted when high with valid |
| in_tag | input | TAG_W | Destination channel tag |
| in_addr | input | FULL_AW | Full response address (prefix and local) |
| in_data | input | DATA_W | Response data |
| prn_valid | output | 1 | Printer output valid |
| prn_ready | input | 1 | Printer ready |
| prn_addr | output | FULL_AW | Printer full address |
| prn_data | output | DATA_W | Printer data |
| proc_valid | output | NUM_PROC | Per-processor valid |
| proc_ready | input | NUM_PROC | Per-processor ready |
| proc_addr | output | NUM_PROC*LOCAL_AW | Per-processor local addresses, flat |
| proc_data | output | NUM_PROC*DATA_W | Per-processor data, flat |
| bad_tag_err | output | 1 | One-cycle pulse after an out-of-range tag is dropped |

## Verification
The bench holds each destination stalled for several cycles and checks that the held response does not change and that input ready stays low. A design that let the stage reload during a stall would lose or overwrite a response. An out-of-range tag is sent while every output is stalled. A design that routed that tag into the stage would hang or raise a stray valid instead of accepting it at once and pulsing the error. Back-to-back streams and a second response queued behind a stalled one test throughput and per-destination order. Reset is applied while a response is held, to test that the valid clears.

// File: rtl/bcast_pkg.sv
package bcast_pkg;

    typedef enum logic {
        STAGE_BYPASS = 1'b0,
        STAGE_REG    = 1'b1
    } stage_mode_e;

    // number of tag bits needed to name n processors plus the printer
    function automatic int unsigned tag_bits(input int unsigned n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/bcast_decode.sv
module bcast_decode #(
    parameter int unsigned NUM_PROC = 4,
    parameter int unsigned TAG_W    = 3
) (
    input  logic [TAG_W-1:0]  tag,
    output logic [NUM_PROC:0] dest,
    output logic              bad
);
    for (genvar j = 0; j <= NUM_PROC; j++) begin : g_dec
        assign dest[j] = (tag == TAG_W'(j));
    end

    assign bad = ~(|dest);
endmodule

// File: rtl/bcast_stage.sv
module bcast_stage
    import bcast_pkg::*;
#(
    parameter int unsigned W    = 32,
    parameter stage_mode_e MODE = STAGE_REG
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_pl,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_pl
);
    if (MODE == STAGE_REG) begin : g_reg
        logic         full_q;
        logic [W-1:0] pl_q;

        assign in_ready  = ~full_q | out_ready;
        assign out_valid = full_q;
        assign out_pl    = pl_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                full_q <= 1'b0;
                pl_q   <= '0;
            end else if (in_valid && in_ready) begin
                full_q <= 1'b1;
                pl_q   <= in_pl;
            end else if (out_ready) begin
                full_q <= 1'b0;
            end
        end

        // R4
        held_stable_chk: assert property (@(posedge clk) disable iff (rst)
            (out_valid && !out_ready) |=> (out_valid && $stable(out_pl)));
    end else begin : g_pass
        assign in_ready  = out_ready;
        assign out_valid = in_valid;
        assign out_pl    = in_pl;
    end
endmodule

// File: rtl/bcast_fanout.sv
module bcast_fanout #(
    parameter int unsigned NUM_PROC = 4,
    parameter int unsigned LOCAL_AW = 8,
    parameter int unsigned FULL_AW  = 11,
    parameter int unsigned DATA_W   = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         s_valid,
    output logic                         s_ready,
    input  logic [NUM_PROC:0]            s_dest,
    input  logic [FULL_AW-1:0]           s_addr,
    input  logic [DATA_W-1:0]            s_data,
    output logic                         prn_valid,
    input  logic                         prn_ready,
    output logic [FULL_AW-1:0]           prn_addr,
    output logic [DATA_W-1:0]            prn_data,
    output logic [NUM_PROC-1:0]          proc_valid,
    input  logic [NUM_PROC-1:0]          proc_ready,
    output logic [NUM_PROC*LOCAL_AW-1:0] proc_addr,
    output logic [NUM_PROC*DATA_W-1:0]   proc_data
);
    logic [NUM_PROC:0] vld_all;
    logic [NUM_PROC:0] rdy_all;

    assign vld_all    = {(NUM_PROC+1){s_valid}} & s_dest;
    assign rdy_all    = {proc_ready, prn_ready};
    assign s_ready    = |(s_dest & rdy_all);

    assign prn_valid  = vld_all[0];
    assign prn_addr   = s_addr;
    assign prn_data   = s_data;
    assign proc_valid = vld_all[NUM_PROC:1];

    for (genvar k = 0; k < NUM_PROC; k++) begin : g_proc
        assign proc_addr[k*LOCAL_AW +: LOCAL_AW] = s_addr[LOCAL_AW-1:0];
        assign proc_data[k*DATA_W +: DATA_W]     = s_data;
    end

    // R3
    one_dest_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({proc_valid, prn_valid}));
endmodule

// File: rtl/bcast_resp_router.sv
module bcast_resp_router
    import bcast_pkg::*;
#(
    parameter int unsigned NUM_PROC = 4,
    parameter int unsigned LOCAL_AW = 8,
    parameter int unsigned DATA_W   = 16,
    parameter stage_mode_e MODE     = STAGE_REG,
    localparam int unsigned TAG_W   = tag_bits(NUM_PROC),
    localparam int unsigned FULL_AW = LOCAL_AW + TAG_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [TAG_W-1:0]             in_tag,
    input  logic [FULL_AW-1:0]           in_addr,
    input  logic [DATA_W-1:0]            in_data,
    output logic                         prn_valid,
    input  logic                         prn_ready,
    output logic [FULL_AW-1:0]           prn_addr,
    output logic [DATA_W-1:0]            prn_data,
    output logic [NUM_PROC-1:0]          proc_valid,
    input  logic [NUM_PROC-1:0]          proc_ready,
    output logic [NUM_PROC*LOCAL_AW-1:0] proc_addr,
    output logic [NUM_PROC*DATA_W-1:0]   proc_data,
    output logic                         bad_tag_err
);
    typedef struct packed {
        logic [NUM_PROC:0]    dest;
        logic [FULL_AW-1:0]   addr;
        logic [DATA_W-1:0]    data;
    } resp_t;

    localparam logic [TAG_W-1:0] TOP_TAG = TAG_W'(NUM_PROC);

    logic [NUM_PROC:0] dec_dest;
    logic              dec_bad;
    resp_t             in_pl, out_pl;
    logic              st_in_ready, st_out_valid, st_out_ready;
    logic              err_q;

    bcast_decode #(.NUM_PROC(NUM_PROC), .TAG_W(TAG_W)) dec_i (
        .tag (in_tag),
        .dest(dec_dest),
        .bad (dec_bad)
    );

    assign in_pl    = '{dest: dec_dest, addr: in_addr, data: in_data};
    assign in_ready = dec_bad | st_in_ready;

    bcast_stage #(.W($bits(resp_t)), .MODE(MODE)) stage_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid & ~dec_bad),
        .in_ready (st_in_ready),
        .in_pl    (in_pl),
        .out_valid(st_out_valid),
        .out_ready(st_out_ready),
        .out_pl   (out_pl)
    );

    bcast_fanout #(
        .NUM_PROC(NUM_PROC), .LOCAL_AW(LOCAL_AW),
        .FULL_AW(FULL_AW), .DATA_W(DATA_W)
    ) fan_i (
        .clk       (clk),
        .rst       (rst),
        .s_valid   (st_out_valid),
        .s_ready   (st_out_ready),
        .s_dest    (out_pl.dest),
        .s_addr    (out_pl.addr),
        .s_data    (out_pl.data),
        .prn_valid (prn_valid),
        .prn_ready (prn_ready),
        .prn_addr  (prn_addr),
        .prn_data  (prn_data),
        .proc_valid(proc_valid),
        .proc_ready(proc_ready),
        .proc_addr (proc_addr),
        .proc_data (proc_data)
    );

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= in_valid & dec_bad;
    end
    assign bad_tag_err = err_q;

    // R5
    bad_tag_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_tag > TOP_TAG)) |-> in_ready);

    // R5
    err_source_chk: assert property (@(posedge clk) disable iff (rst)
        bad_tag_err |-> $past(in_valid && (in_tag > TOP_TAG)));

    // R8
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!prn_valid && (proc_valid == '0) && !bad_tag_err));
endmodule

// File: tb/bcast_resp_router_tb_top.sv
module bcast_resp_router_tb_top;
    localparam int N   = 4;
    localparam int LAW = 8;
    localparam int DW  = 16;
    localparam int TW  = 3;
    localparam int FAW = LAW + TW;

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid;
    logic            in_ready;
    logic [TW-1:0]   in_tag;
    logic [FAW-1:0]  in_addr;
    logic [DW-1:0]   in_data;
    logic            prn_valid;
    logic            prn_ready;
    logic [FAW-1:0]  prn_addr;
    logic [DW-1:0]   prn_data;
    logic [N-1:0]    proc_valid;
    logic [N-1:0]    proc_ready;
    logic [N*LAW-1:0] proc_addr;
    logic [N*DW-1:0] proc_data;
    logic            bad_tag_err;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    bcast_resp_router #(.NUM_PROC(N), .LOCAL_AW(LAW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_tag(in_tag),
        .in_addr(in_addr), .in_data(in_data),
        .prn_valid(prn_valid), .prn_ready(prn_ready),
        .prn_addr(prn_addr), .prn_data(prn_data),
        .proc_valid(proc_valid), .proc_ready(proc_ready),
        .proc_addr(proc_addr), .proc_data(proc_data),
        .bad_tag_err(bad_tag_err)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [TW-1:0] t, input logic [FAW-1:0] a,
                        input logic [DW-1:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_tag = t; in_addr = a; in_data = d;
        forever begin
            #1;
            if (in_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic test_reset();
        chk("R8", "prn_valid after reset", 64'(prn_valid), 64'd0);
        chk("R8", "proc_valid after reset", 64'(proc_valid), 64'd0);
        chk("R8", "err after reset", 64'(bad_tag_err), 64'd0);
        chk("R8", "in_ready after reset", 64'(in_ready), 64'd1);
    endtask

    task automatic test_printer();
        send(3'd0, 11'h5A5, 16'hBEEF);
        chk("R1", "prn_valid", 64'(prn_valid), 64'd1);
        chk("R1", "prn_addr full", 64'(prn_addr), 64'h5A5);
        chk("R1", "prn_data", 64'(prn_data), 64'hBEEF);
        chk("R3", "no proc valid", 64'(proc_valid), 64'd0);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            chk("R4", "stalled prn_valid", 64'(prn_valid), 64'd1);
            chk("R4", "stalled prn_addr", 64'(prn_addr), 64'h5A5);
            chk("R4", "stalled prn_data", 64'(prn_data), 64'hBEEF);
            chk("R4", "in_ready low in stall", 64'(in_ready), 64'd0);
        end
        @(negedge clk); prn_ready = 1'b1;
        @(posedge clk); #1;
        chk("R1", "prn_valid drops after accept", 64'(prn_valid), 64'd0);
        @(negedge clk); prn_ready = 1'b0;
    endtask

    task automatic test_procs();
        for (int k = 0; k < N; k++) begin
            send(3'(k + 1), {3'(k), 8'(8'h30 + k)}, 16'(16'h1000 + k));
            chk("R2", "proc_valid onehot", 64'(proc_valid), 64'(1 << k));
            chk("R3", "printer idle", 64'(prn_valid), 64'd0);
            chk("R2", "proc local addr", 64'(proc_addr[k*LAW +: LAW]), 64'(8'h30 + k));
            chk("R2", "proc data", 64'(proc_data[k*DW +: DW]), 64'(16'h1000 + k));
            @(negedge clk); proc_ready[k] = 1'b1;
            @(posedge clk); #1;
            chk("R2", "proc valid drops", 64'(proc_valid), 64'd0);
            @(negedge clk); proc_ready = '0;
        end
    endtask

    task automatic test_bad_tag();
        @(negedge clk);
        in_valid = 1'b1; in_tag = 3'd6; in_addr = 11'h7FF; in_data = 16'hDEAD;
        #1;
        chk("R5", "in_ready for bad tag", 64'(in_ready), 64'd1);
        @(posedge clk); #1;
        in_valid = 1'b0;
        chk("R5", "err pulse", 64'(bad_tag_err), 64'd1);
        chk("R5", "no prn valid", 64'(prn_valid), 64'd0);
        chk("R5", "no proc valid", 64'(proc_valid), 64'd0);
        @(posedge clk); #1;
        chk("R5", "err one cycle", 64'(bad_tag_err), 64'd0);
        chk("R5", "still no valid", 64'({proc_valid, prn_valid}), 64'd0);
    endtask

    task automatic test_stream();
        @(negedge clk); proc_ready = '1; prn_ready = 1'b1;
        for (int i = 0; i < 3; i++) begin
            if (i > 0) @(negedge clk);
            in_valid = 1'b1; in_tag = 3'd2; in_addr = 11'h120; in_data = 16'(16'hA000 + i);
            #1;
            chk("R6", "in_ready during stream", 64'(in_ready), 64'd1);
            @(posedge clk); #1;
            chk("R6", "proc1 valid next cycle", 64'(proc_valid), 64'b0010);
            chk("R6", "proc1 data in order", 64'(proc_data[DW +: DW]), 64'(16'hA000 + i));
        end
        in_valid = 1'b0;
        @(posedge clk); #1;
        chk("R6", "stream drained", 64'(proc_valid), 64'd0);
        @(negedge clk); proc_ready = '0; prn_ready = 1'b0;
    endtask

    task automatic test_order();
        send(3'd3, 11'h255, 16'hC000);
        @(negedge clk);
        in_valid = 1'b1; in_tag = 3'd3; in_addr = 11'h256; in_data = 16'hC001;
        #1;
        chk("R7", "second held off", 64'(in_ready), 64'd0);
        @(negedge clk); #1;
        chk("R7", "first still presented", 64'(proc_data[2*DW +: DW]), 64'hC000);
        @(negedge clk); proc_ready[2] = 1'b1;
        #1;
        chk("R7", "ready passes through", 64'(in_ready), 64'd1);
        @(posedge clk); #1;
        in_valid = 1'b0;
        chk("R7", "second follows", 64'(proc_data[2*DW +: DW]), 64'hC001);
        chk("R7", "second valid", 64'(proc_valid), 64'b0100);
        chk("R7", "second local addr", 64'(proc_addr[2*LAW +: LAW]), 64'h56);
        @(posedge clk); #1;
        chk("R7", "drained", 64'(proc_valid), 64'd0);
        @(negedge clk); proc_ready = '0;
    endtask

    task automatic test_mid_reset();
        send(3'd4, 11'h4AA, 16'h5555);
        chk("R8", "held before reset", 64'(proc_valid), 64'b1000);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        chk("R8", "valid cleared by reset", 64'({proc_valid, prn_valid}), 64'd0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R8", "stays clear after reset", 64'({proc_valid, prn_valid}), 64'd0);
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_tag = '0; in_addr = '0; in_data = '0;
        prn_ready = 1'b0; proc_ready = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        test_reset();
        test_printer();
        test_procs();
        test_bad_tag();
        test_stream();
        test_order();
        test_mid_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule